// File: doc/BRIEF.md
# Pipelined Block SAD Processing Element

This block computes the sum of absolute differences between a 16x16 block of current-frame pixels and one candidate reference block, as one processing element of a motion-estimation search engine. A controller streams the 256 pixel pairs of a block in 32 beats of eight 8-bit pairs each. Each pair goes through a bitwise magnitude comparator and XOR-based conditional inversion to form its absolute difference. The eight differences are folded by a carry-save tree of 5:2 compressors (each built from 3:2 cells), resolved by one carry-propagate adder and added into a 16-bit accumulator.

The element is a four-stage pipeline: absolute difference, compression, final addition, accumulation. A beat enters only while `en` is 1, so the controller may insert idle cycles freely. A synchronous `clr` input from the controller discards the partial sum and any beats in flight. When the last beat of a block has passed the accumulator, the block's SAD is presented with a one-cycle valid pulse. The next block may follow with no gap and no clear.

Top module: `sad_pe`

## Requirements
- R1: After reset, `sad` is 0 and `sad_valid` is 0.
- R2: Lane i of a beat uses bits [8i+7:8i] of `cur_pix` and `ref_pix`, and it contributes |cur - ref| to the sum, whichever of the two pixels is larger, including equal pixels (contribution 0).
- R3: A block is exactly 32 accepted beats (cycles with `en`=1 and `clr`=0), and the reported `sad` is the sum of all 256 absolute differences of that block.
- R4: `sad_valid` is 1 for exactly one cycle, on the cycle that follows the fourth rising edge counting the edge that samples the block's last beat. `sad` carries the block result in that cycle and holds it until the next block's first beat reaches the accumulator or `clr` is applied.
- R5: Cycles with `en`=0 are bubbles: the pixel inputs are ignored, the beat count is not advanced, and the result and its timing relative to the last beat are unchanged.
- R6: `clr`=1 sampled at an edge sets `sad` to 0 and `sad_valid` to 0 in the following cycle, discards beats still in the pipeline, drops any beat presented in that cycle, and restarts the beat count so the next accepted beat begins a new block.
- R7: Blocks may be streamed back to back with no idle cycle and no clear, and each block's result is independent of the block before it.
- R8: The accumulator holds the largest possible block SAD, 256 x 255 = 65280, without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the sum, pipeline and beat count |
| en | input | 1 | Beat strobe: pixel inputs are taken while 1 |
| cur_pix | input | 64 | Eight current-block pixels, lane i in bits [8i+7:8i] |
| ref_pix | input | 64 | Eight reference-block pixels, same lane layout |
| sad | output | 16 | Accumulated sum of absolute differences |
| sad_valid | output | 1 | One-cycle pulse marking a completed block result |

## Verification
The bench builds the element with its default parameters: 8-bit pixels, eight lanes and 32 beats per block. With eight lanes the compressor chain runs two 5:2 steps with no standalone 3:2 tail, and the 16-bit accumulator is sized exactly for the 65280 ceiling. The 0-versus-255 blocks in both directions therefore reach the full comparator swing and the top of the accumulator. Random blocks, blocks with bubbles carrying junk pixels, back-to-back blocks and a mid-block clear cover the first-beat restart and the fixed four-edge latency.

// File: rtl/sad_pkg.sv
package sad_pkg;

   // Control token that travels alongside each beat through the pipeline.
   typedef struct packed {
      logic vld;     // beat present in this stage
      logic first;   // beat opens a block
      logic last;    // beat closes a block
   } beat_tag_t;

endpackage

// File: rtl/sad_absdiff.sv
// Absolute difference of two unsigned pixels: a comparator tree built from
// single-bit greater/equal cells selects which operand is inverted, and a
// single adder with carry-in forms the difference.
module sad_absdiff #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] d
);
   localparam int LV = (W > 1) ? $clog2(W) : 0;
   localparam int P2 = 1 << LV;

   initial begin
      assert (W >= 1) else $error("sad_absdiff: W must be at least 1");
   end

   // Level 0 holds per-bit cells, each higher level merges adjacent pairs,
   // the upper (more significant) half taking priority.
   for (genvar lv = 0; lv <= LV; lv++) begin : g_lv
      localparam int N = P2 >> lv;
      logic [N-1:0] g;
      logic [N-1:0] e;
      if (lv == 0) begin : g_leaf
         for (genvar i = 0; i < N; i++) begin : g_bit
            if (i < W) begin : g_real
               assign g[i] = a[i] & ~b[i];
               assign e[i] = ~(a[i] ^ b[i]);
            end else begin : g_pad
               assign g[i] = 1'b0;
               assign e[i] = 1'b1;
            end
         end
      end else begin : g_node
         for (genvar j = 0; j < N; j++) begin : g_pair
            assign g[j] = g_lv[lv-1].g[2*j+1] |
                          (g_lv[lv-1].e[2*j+1] & g_lv[lv-1].g[2*j]);
            assign e[j] = g_lv[lv-1].e[2*j+1] & g_lv[lv-1].e[2*j];
         end
      end
   end

   logic          a_gt_b;
   logic          a_eq_b;
   logic          swap;
   logic [W-1:0]  x_op;
   logic [W-1:0]  y_op;

   assign a_gt_b = g_lv[LV].g[0];
   assign a_eq_b = g_lv[LV].e[0];
   assign swap   = ~a_gt_b & ~a_eq_b;     // a < b

   // swap=0: a + ~b + 1 = a - b ; swap=1: ~a + b + 1 = b - a
   assign x_op = a ^ {W{swap}};
   assign y_op = b ^ {W{~swap}};
   assign d    = x_op + y_op + W'(1);

endmodule

// File: rtl/sad_csa32.sv
// Word-wide 3:2 carry-save cell; the carry word is shifted one place left
// and the carry out of the top bit is dropped (results are modulo 2^W).
module sad_csa32 #(
   parameter int W = 11
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic [W-1:0] z,
   output logic [W-1:0] s,
   output logic [W-1:0] c
);
   logic [W-1:0] maj;

   initial begin
      assert (W >= 2) else $error("sad_csa32: W must be at least 2");
   end

   assign s   = x ^ y ^ z;
   assign maj = (x & y) | (x & z) | (y & z);
   assign c   = {maj[W-2:0], 1'b0};

endmodule

// File: rtl/sad_csa52.sv
// Word-wide 5:2 compressor assembled from three chained 3:2 cells.
module sad_csa52 #(
   parameter int W = 11
) (
   input  logic [W-1:0] i0,
   input  logic [W-1:0] i1,
   input  logic [W-1:0] i2,
   input  logic [W-1:0] i3,
   input  logic [W-1:0] i4,
   output logic [W-1:0] s,
   output logic [W-1:0] c
);
   logic [W-1:0] s_a, c_a, s_b, c_b;

   sad_csa32 #(.W(W)) u_first  (.x(i0),  .y(i1),  .z(i2), .s(s_a), .c(c_a));
   sad_csa32 #(.W(W)) u_second (.x(s_a), .y(c_a), .z(i3), .s(s_b), .c(c_b));
   sad_csa32 #(.W(W)) u_third  (.x(s_b), .y(c_b), .z(i4), .s(s),   .c(c));

endmodule

// File: rtl/sad_csa_tree.sv
// Reduces N words to a sum/carry pair. The first two words seed the pair;
// each 5:2 step absorbs three more words, and the leftover one or two words
// are absorbed by single 3:2 steps.
module sad_csa_tree #(
   parameter int W = 11,
   parameter int N = 8
) (
   input  logic [N*W-1:0] vin,
   output logic [W-1:0]   s_o,
   output logic [W-1:0]   c_o
);
   localparam int NUM5  = (N - 2) / 3;
   localparam int REM   = (N - 2) % 3;
   localparam int STEPS = NUM5 + REM;

   initial begin
      assert (N >= 2) else $error("sad_csa_tree: N must be at least 2");
   end

   for (genvar k = 0; k <= STEPS; k++) begin : g_st
      logic [W-1:0] s;
      logic [W-1:0] c;
      if (k == 0) begin : g_seed
         assign s = vin[0 +: W];
         assign c = vin[W +: W];
      end else if (k <= NUM5) begin : g_five
         localparam int B = 2 + 3 * (k - 1);
         sad_csa52 #(.W(W)) u_c52 (
            .i0 (g_st[k-1].s),
            .i1 (g_st[k-1].c),
            .i2 (vin[B*W +: W]),
            .i3 (vin[(B+1)*W +: W]),
            .i4 (vin[(B+2)*W +: W]),
            .s  (s),
            .c  (c)
         );
      end else begin : g_three
         localparam int B = 2 + 3 * NUM5 + (k - NUM5 - 1);
         sad_csa32 #(.W(W)) u_c32 (
            .x (g_st[k-1].s),
            .y (g_st[k-1].c),
            .z (vin[B*W +: W]),
            .s (s),
            .c (c)
         );
      end
   end

   assign s_o = g_st[STEPS].s;
   assign c_o = g_st[STEPS].c;

endmodule

// File: rtl/sad_pe.sv
// Four-stage SAD processing element:
//   stage 1 absolute differences, stage 2 carry-save reduction,
//   stage 3 carry-propagate add, stage 4 accumulation.
module sad_pe
   import sad_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int LANES = 8,
   parameter int BEATS = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     en,
   input  logic [LANES*PIX_W-1:0]   cur_pix,
   input  logic [LANES*PIX_W-1:0]   ref_pix,
   output logic [PIX_W+$clog2(LANES*BEATS)-1:0] sad,
   output logic                     sad_valid
);
   localparam int DSUM_W = PIX_W + $clog2(LANES);
   localparam int ACC_W  = PIX_W + $clog2(LANES * BEATS);
   localparam int CNT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BEATS - 1);

   initial begin
      assert (PIX_W >= 1) else $error("sad_pe: PIX_W must be at least 1");
      assert (LANES >= 2) else $error("sad_pe: LANES must be at least 2");
      assert (BEATS >= 1) else $error("sad_pe: BEATS must be at least 1");
   end

   // ---------------- beat counter ----------------
   logic [CNT_W-1:0] beat_cnt;
   logic             take;

   assign take = en & ~clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         beat_cnt <= '0;
      else if (clr)
         beat_cnt <= '0;
      else if (en)
         beat_cnt <= (beat_cnt == LAST_CNT) ? '0 : beat_cnt + CNT_W'(1);
   end

   // ---------------- stage 1: absolute differences ----------------
   logic [PIX_W-1:0]        ad [LANES];
   logic [LANES*DSUM_W-1:0] d_next;
   logic [LANES*DSUM_W-1:0] d1;
   beat_tag_t               t1, t2, t3;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      sad_absdiff #(.W(PIX_W)) u_abs (
         .a (cur_pix[i*PIX_W +: PIX_W]),
         .b (ref_pix[i*PIX_W +: PIX_W]),
         .d (ad[i])
      );
      assign d_next[i*DSUM_W +: DSUM_W] = DSUM_W'(ad[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t1 <= '0;
         d1 <= '0;
      end else begin
         t1.vld   <= take;
         t1.first <= take & (beat_cnt == '0);
         t1.last  <= take & (beat_cnt == LAST_CNT);
         if (take)
            d1 <= d_next;
      end
   end

   // ---------------- stage 2: carry-save reduction ----------------
   logic [DSUM_W-1:0] s_cmb, c_cmb;
   logic [DSUM_W-1:0] s2, c2;

   sad_csa_tree #(.W(DSUM_W), .N(LANES)) u_tree (
      .vin (d1),
      .s_o (s_cmb),
      .c_o (c_cmb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t2 <= '0;
         s2 <= '0;
         c2 <= '0;
      end else begin
         t2 <= clr ? '0 : t1;
         if (t1.vld) begin
            s2 <= s_cmb;
            c2 <= c_cmb;
         end
      end
   end

   // ---------------- stage 3: carry-propagate addition ----------------
   logic [DSUM_W-1:0] sum3;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t3   <= '0;
         sum3 <= '0;
      end else begin
         t3 <= clr ? '0 : t2;
         if (t2.vld)
            sum3 <= s2 + c2;
      end
   end

   // ---------------- stage 4: accumulation ----------------
   logic [ACC_W-1:0] acc;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         done_q <= 1'b0;
      end else if (clr) begin
         acc    <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= t3.vld & t3.last;
         if (t3.vld)
            acc <= t3.first ? ACC_W'(sum3) : acc + ACC_W'(sum3);
      end
   end

   assign sad       = acc;
   assign sad_valid = done_q;

   // ---------------- assertions ----------------
   function automatic logic [PIX_W-1:0] abs_ref(input logic [PIX_W-1:0] a,
                                                 input logic [PIX_W-1:0] b);
      return (a > b) ? (a - b) : (b - a);
   endfunction

   function automatic logic [DSUM_W-1:0] lane_total(input logic [LANES*DSUM_W-1:0] v);
      logic [DSUM_W-1:0] t;
      t = '0;
      for (int i = 0; i < LANES; i++)
         t = t + v[i*DSUM_W +: DSUM_W];
      return t;
   endfunction

   // R2: comparator-plus-inversion result matches the arithmetic distance
   a_r2_absdiff_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      t1.vld |-> d1[0 +: DSUM_W] ==
         DSUM_W'(abs_ref($past(cur_pix[0 +: PIX_W]), $past(ref_pix[0 +: PIX_W]))));

   a_r2_absdiff_top: assert property (@(posedge clk) disable iff (!rst_n)
      t1.vld |-> d1[(LANES-1)*DSUM_W +: DSUM_W] ==
         DSUM_W'(abs_ref($past(cur_pix[(LANES-1)*PIX_W +: PIX_W]),
                         $past(ref_pix[(LANES-1)*PIX_W +: PIX_W]))));

   // R3: compressor tree plus final adder equal the plain lane total
   a_r3_beat_total: assert property (@(posedge clk) disable iff (!rst_n)
      t3.vld |-> sum3 == $past(lane_total(d1), 2));

   // R7: a first beat restarts the sum regardless of earlier blocks
   a_r7_first_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (t3.vld && t3.first && !clr) |=> acc == ACC_W'($past(sum3)));

   // R8: continuing beats never wrap the accumulator
   a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (t3.vld && !t3.first && !clr) |=> acc >= $past(acc));

   // R5: with no beat arriving the result is held
   a_r5_bubble_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!t3.vld && !clr) |=> $stable(acc));

   // R6: clear empties the result
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sad == '0) && !sad_valid);

   // R4: the valid flag is a single-cycle pulse
   if (BEATS > 1) begin : g_pulse_chk
      a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
         sad_valid |=> !sad_valid);
   end

endmodule

// File: tb/sad_pe_tb_top.sv
module sad_pe_tb_top;
   localparam int PIX_W = 8;
   localparam int LANES = 8;
   localparam int BEATS = 32;
   localparam int ACC_W = 16;

   logic                   clk = 1'b0;
   logic                   rst_n;
   logic                   clr;
   logic                   en;
   logic [LANES*PIX_W-1:0] cur_pix;
   logic [LANES*PIX_W-1:0] ref_pix;
   logic [ACC_W-1:0]       sad;
   logic                   sad_valid;

   always #5 clk = ~clk;

   sad_pe #(.PIX_W(PIX_W), .LANES(LANES), .BEATS(BEATS)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .en        (en),
      .cur_pix   (cur_pix),
      .ref_pix   (ref_pix),
      .sad       (sad),
      .sad_valid (sad_valid)
   );

   int    cyc = 0;
   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;
   int    exp_sad_q[$];
   int    exp_cyc_q[$];
   string exp_tag_q[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // Monitor: pops the scoreboard whenever a result is flagged.
   always @(negedge clk) begin
      if (rst_n === 1'b1 && sad_valid === 1'b1) begin
         if (exp_sad_q.size() == 0) begin
            check(1'b0, "R4 unexpected sad_valid", 1, 0);
         end else begin
            int    e_sad;
            int    e_cyc;
            string e_tag;
            e_sad = exp_sad_q.pop_front();
            e_cyc = exp_cyc_q.pop_front();
            e_tag = exp_tag_q.pop_front();
            check(int'(sad) == e_sad, {e_tag, " R3 block sum"}, int'(sad), e_sad);
            check(cyc == e_cyc, {e_tag, " R4 result cycle"}, cyc, e_cyc);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         en      = 1'b0;
         cur_pix = {$urandom(), $urandom()};
         ref_pix = {$urandom(), $urandom()};
      end
   endtask

   // mode 0 random, 1 cur=0/ref=255, 2 cur=255/ref=0, 3 equal random
   task automatic drive_beat(input int mode, inout int total);
      for (int i = 0; i < LANES; i++) begin
         logic [PIX_W-1:0] c, r;
         case (mode)
            1: begin c = 8'd0;   r = 8'd255; end
            2: begin c = 8'd255; r = 8'd0;   end
            3: begin c = 8'($urandom()); r = c; end
            default: begin c = 8'($urandom()); r = 8'($urandom()); end
         endcase
         cur_pix[i*PIX_W +: PIX_W] = c;
         ref_pix[i*PIX_W +: PIX_W] = r;
         total += (c > r) ? int'(c) - int'(r) : int'(r) - int'(c);
      end
      en = 1'b1;
   endtask

   // Driver: one full block; gap>0 inserts bubbles with junk pixels.
   task automatic run_block(input int mode, input int gap, input string tag);
      int total = 0;
      for (int b = 0; b < BEATS; b++) begin
         if (gap > 0 && (b % 3) == 1) idle(gap);
         @(negedge clk);
         drive_beat(mode, total);
      end
      // last beat sampled at the next edge (cycle cyc+1); result seen three edges later
      exp_sad_q.push_back(total);
      exp_cyc_q.push_back(cyc + 4);
      exp_tag_q.push_back(tag);
   endtask

   initial begin
      rst_n   = 1'b0;
      clr     = 1'b0;
      en      = 1'b0;
      cur_pix = '0;
      ref_pix = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(sad == '0, "R1 reset sad", int'(sad), 0);
      check(sad_valid == 1'b0, "R1 reset valid", int'(sad_valid), 0);

      run_block(3, 0, "R2 equal pixels");
      idle(6);
      run_block(1, 0, "R8 R2 cur=0 ref=255");
      idle(6);
      run_block(2, 0, "R8 R2 cur=255 ref=0");
      idle(10);
      check(int'(sad) == 65280, "R4 R5 result held while idle", int'(sad), 65280);

      run_block(0, 0, "R3 random a");
      idle(6);
      run_block(0, 0, "R3 random b");
      idle(6);
      run_block(0, 2, "R5 bubbles with junk pixels");
      idle(6);
      run_block(0, 1, "R5 single-cycle bubbles");
      idle(6);

      run_block(0, 0, "R7 back-to-back first");
      run_block(2, 0, "R7 back-to-back second");
      run_block(0, 0, "R7 back-to-back third");
      idle(8);

      // R6: partial block then clear, with beats still in flight
      begin
         int junk = 0;
         for (int b = 0; b < 12; b++) begin
            @(negedge clk);
            drive_beat(2, junk);
         end
      end
      @(negedge clk);
      clr = 1'b1;
      en  = 1'b1;          // beat offered together with clr is dropped
      @(negedge clk);
      clr = 1'b0;
      en  = 1'b0;
      check(sad == '0, "R6 sad after clear", int'(sad), 0);
      check(sad_valid == 1'b0, "R6 valid after clear", int'(sad_valid), 0);
      idle(8);
      check(sad == '0, "R6 in-flight beats discarded", int'(sad), 0);
      run_block(0, 0, "R6 block after clear");
      idle(8);

      check(exp_sad_q.size() == 0, "R4 missing results", exp_sad_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=0", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule